// File: doc/BRIEF.md
# Completion Interrupt Moderation Unit

This block sits between a completion queue and an interrupt controller. It decides when a run of completion events should turn into an interrupt. It counts pending completions and runs a period timer that advances on a microsecond tick strobe. An interrupt is raised when the pending count reaches a configured maximum, or when the period timer expires while events are pending, whichever comes first.

The period mode decides when the timer restarts. In interrupt-start mode it restarts only when an interrupt is raised. In completion-start mode it also restarts on every new completion. In that mode a dense burst never lets the timer expire, so only the count limit produces interrupts. Once the burst stops, an interrupt follows one period after the last completion.

Configuration is written only while the unit is inactive. Taking the unit down discards all pending state. Selecting a mode loads that mode's default period and count. A separate write can then override both values.

Top module: `irqmod_unit`

## Requirements
- R1: After reset the mode is interrupt-start (`mode_val` 0), the period is 16 ticks, the count limit is 32 and `irq` is low.
- R2: When a completion brings the pending count up to a nonzero count limit, `irq` pulses in the next cycle, whatever the timer holds.
- R3: In interrupt-start mode, completions do not restart the timer. With pending events, `irq` pulses in the cycle after the tick that makes the number of ticks since the first pending event equal to a nonzero period.
- R4: In completion-start mode (`mode_val` 1), every completion restarts the timer. Completions spaced closer than the period never let it expire, and `irq` pulses in the cycle after the period-th tick that follows the last completion.
- R5: A mode write while inactive loads the period default of that mode (16 ticks for interrupt-start, 3 for completion-start) and a count limit of 32.
- R6: A parameter write while inactive sets the period and the count limit. If it coincides with a mode write, the mode comes from the mode write and the period and count from the parameter write.
- R7: Mode and parameter writes made while `active` is high have no effect.
- R8: While `active` is low, `irq` stays low. Pending events and timer progress from before the unit went down are discarded.
- R9: With both a period and a count limit of 0, every completion gives an `irq` pulse in the next cycle.
- R10: Each interrupt clears the pending count. The timer runs only while events are pending, so an idle queue never produces an interrupt.
- R11: A completion that arrives in the cycle in which `irq` is high is counted toward the next interrupt. In completion-start mode it also restarts the timer.
- R12: The timer advances only on cycles with `tick` high. A timer expiry and a count hit in the same cycle produce a single one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| active | input | 1 | Unit is up; low discards pending state and permits configuration |
| mode_wr | input | 1 | Mode write strobe, honoured only while inactive |
| mode_val | input | 1 | Mode to write: 0 interrupt-start, 1 completion-start |
| parm_wr | input | 1 | Period/count write strobe, honoured only while inactive |
| period_val | input | PER_W | Period in ticks to write; 0 disables the timer |
| count_val | input | CNT_W | Count limit to write; 0 disables the count trigger |
| evt | input | 1 | One-cycle pulse per completion event |
| tick | input | 1 | Microsecond tick strobe |
| irq | output | 1 | Registered one-cycle interrupt pulse |

## Verification
Each interrupt decision is registered once. The response to a completion or tick that is sampled at one rising edge is therefore visible on `irq` in the cycle right after it. The bench drives each stimulus at a falling edge and reads `irq` at the following falling edge, so every sample belongs to exactly one input cycle. Sweeps over small periods and count limits, in both modes, compare the cycle of every pulse with a position computed from the tick and event indices. Configuration writes take effect at the edge that samples them, and no checked stimulus is applied in that same cycle.

// File: rtl/irqmod_pkg.sv
package irqmod_pkg;
  typedef enum logic {
    PM_IRQ_START = 1'b0,
    PM_EVT_START = 1'b1
  } pmode_e;
endpackage

// File: rtl/irqmod_cfg.sv
module irqmod_cfg
  import irqmod_pkg::*;
#(
  parameter int PER_W          = 8,
  parameter int CNT_W          = 8,
  parameter int DEF_PERIOD_IRQ = 16,
  parameter int DEF_PERIOD_EVT = 3,
  parameter int DEF_COUNT      = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic             mode_wr,
  input  logic             mode_val,
  input  logic             parm_wr,
  input  logic [PER_W-1:0] period_val,
  input  logic [CNT_W-1:0] count_val,
  output pmode_e           mode_q,
  output logic [PER_W-1:0] period_q,
  output logic [CNT_W-1:0] count_q
);
  localparam logic [PER_W-1:0] PER_I = PER_W'(DEF_PERIOD_IRQ);
  localparam logic [PER_W-1:0] PER_E = PER_W'(DEF_PERIOD_EVT);
  localparam logic [CNT_W-1:0] CNT_D = CNT_W'(DEF_COUNT);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= PM_IRQ_START;
      period_q <= PER_I;
      count_q  <= CNT_D;
    end else if (!active) begin
      if (mode_wr) begin
        mode_q   <= pmode_e'(mode_val);
        period_q <= mode_val ? PER_E : PER_I;
        count_q  <= CNT_D;
      end
      if (parm_wr) begin
        period_q <= period_val;
        count_q  <= count_val;
      end
    end
  end
endmodule

// File: rtl/irqmod_evcnt.sv
module irqmod_evcnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             fire,
  input  logic             evt,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_sum
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_comb begin
    if (cnt_q == CNT_MAX) cnt_sum = cnt_q;
    else                  cnt_sum = cnt_q + CNT_W'(evt);
  end

  always_ff @(posedge clk) begin
    if (rst || flush || fire) cnt_q <= '0;
    else                      cnt_q <= cnt_sum;
  end
endmodule

// File: rtl/irqmod_timer.sv
module irqmod_timer #(
  parameter int PER_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             fire,
  input  logic             restart,
  input  logic             run,
  input  logic             tick,
  input  logic [PER_W-1:0] period,
  output logic [PER_W-1:0] tmr_q,
  output logic             expire
);
  localparam logic [PER_W-1:0] TMR_MAX = '1;

  logic [PER_W:0] tmr_plus;
  logic           advance;

  assign tmr_plus = {1'b0, tmr_q} + (PER_W+1)'(1);
  assign advance  = run && tick && !restart;
  assign expire   = advance && (period != '0) && (tmr_plus >= {1'b0, period});

  always_ff @(posedge clk) begin
    if (rst || flush || fire || restart) tmr_q <= '0;
    else if (advance && tmr_q != TMR_MAX) tmr_q <= tmr_plus[PER_W-1:0];
  end
endmodule

// File: rtl/irqmod_unit.sv
module irqmod_unit
  import irqmod_pkg::*;
#(
  parameter int PER_W          = 8,
  parameter int CNT_W          = 8,
  parameter int DEF_PERIOD_IRQ = 16,
  parameter int DEF_PERIOD_EVT = 3,
  parameter int DEF_COUNT      = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic             mode_wr,
  input  logic             mode_val,
  input  logic             parm_wr,
  input  logic [PER_W-1:0] period_val,
  input  logic [CNT_W-1:0] count_val,
  input  logic             evt,
  input  logic             tick,
  output logic             irq
);
  pmode_e           mode_q;
  logic [PER_W-1:0] period_q;
  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] pend_cnt;
  logic [CNT_W-1:0] pend_sum;
  logic [PER_W-1:0] tmr_cnt;
  logic             tmr_expire;
  logic             flush, fire, restart;
  logic             hit_cnt, hit_tmr, bypass;

  irqmod_cfg #(
    .PER_W(PER_W), .CNT_W(CNT_W), .DEF_PERIOD_IRQ(DEF_PERIOD_IRQ),
    .DEF_PERIOD_EVT(DEF_PERIOD_EVT), .DEF_COUNT(DEF_COUNT)
  ) u_cfg (
    .clk(clk), .rst(rst), .active(active), .mode_wr(mode_wr),
    .mode_val(mode_val), .parm_wr(parm_wr), .period_val(period_val),
    .count_val(count_val), .mode_q(mode_q), .period_q(period_q),
    .count_q(count_q)
  );

  assign flush   = !active;
  assign restart = (mode_q == PM_EVT_START) && evt;

  irqmod_evcnt #(.CNT_W(CNT_W)) u_evcnt (
    .clk(clk), .rst(rst), .flush(flush), .fire(fire), .evt(evt),
    .cnt_q(pend_cnt), .cnt_sum(pend_sum)
  );

  irqmod_timer #(.PER_W(PER_W)) u_timer (
    .clk(clk), .rst(rst), .flush(flush), .fire(fire), .restart(restart),
    .run(pend_cnt != '0), .tick(tick), .period(period_q),
    .tmr_q(tmr_cnt), .expire(tmr_expire)
  );

  assign hit_cnt = (count_q != '0) && (pend_sum >= count_q);
  assign hit_tmr = tmr_expire;
  assign bypass  = (period_q == '0) && (count_q == '0) && evt;
  assign fire    = active && (hit_cnt || hit_tmr || bypass);

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= fire;
  end
endmodule

// File: rtl/irqmod_unit_chk.sv
module irqmod_unit_chk #(
  parameter int PER_W = 8,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             active,
  input logic             evt,
  input logic             irq,
  input logic [CNT_W-1:0] pend,
  input logic [PER_W-1:0] tmr,
  input logic [CNT_W-1:0] cnt_lim,
  input logic [PER_W-1:0] per_lim
);
  AST_INACTIVE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !active |=> !irq); // R8
  AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(evt || pend != '0)); // R10
  AST_CLEAR_ON_IRQ: assert property (@(posedge clk) disable iff (rst)
    irq |-> pend == '0); // R10
  AST_PEND_BELOW_LIMIT: assert property (@(posedge clk) disable iff (rst)
    (cnt_lim != '0) |-> pend < cnt_lim); // R2
  AST_TIMER_IDLE: assert property (@(posedge clk) disable iff (rst)
    (pend == '0) |-> tmr == '0); // R10
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (active && $past(active)) |-> ($stable(per_lim) && $stable(cnt_lim))); // R7
  AST_BYPASS_EACH: assert property (@(posedge clk) disable iff (rst)
    (active && per_lim == '0 && cnt_lim == '0 && evt) |=> irq); // R9
endmodule

bind irqmod_unit irqmod_unit_chk #(.PER_W(PER_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .active(active), .evt(evt), .irq(irq),
  .pend(pend_cnt), .tmr(tmr_cnt), .cnt_lim(count_q), .per_lim(period_q)
);

// File: tb/tb_irqmod_unit.sv
module tb_irqmod_unit;
  localparam int PER_W = 8;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst, active, mode_wr, mode_val, parm_wr, evt, tick, irq;
  logic [PER_W-1:0] period_val;
  logic [CNT_W-1:0] count_val;

  int n_chk = 0, n_fail = 0, irq_tot = 0, cyc_n = 0;
  logic last_irq;

  always #10 clk = ~clk;

  irqmod_unit #(.PER_W(PER_W), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst(rst), .active(active), .mode_wr(mode_wr),
    .mode_val(mode_val), .parm_wr(parm_wr), .period_val(period_val),
    .count_val(count_val), .evt(evt), .tick(tick), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input logic e, input logic t);
    evt = e; tick = t;
    @(negedge clk);
    last_irq = irq;
    if (irq) irq_tot++;
    evt = 1'b0; tick = 1'b0;
  endtask

  task automatic go(input logic up);
    active = up;
    cyc(0, 0);
  endtask

  task automatic wr_mode(input logic m);
    mode_wr = 1'b1; mode_val = m;
    cyc(0, 0);
    mode_wr = 1'b0;
  endtask

  task automatic wr_parm(input int p, input int c);
    parm_wr = 1'b1; period_val = PER_W'(p); count_val = CNT_W'(c);
    cyc(0, 0);
    parm_wr = 1'b0;
  endtask

  task automatic setup(input logic m, input int p, input int c);
    go(0); wr_mode(m); wr_parm(p, c); go(1);
  endtask

  // run n cycles of given input; return number of irq pulses seen
  task automatic run(input int n, input logic e, input logic t, output int hits);
    int b;
    b = irq_tot;
    for (int i = 0; i < n; i++) cyc(e, t);
    hits = irq_tot - b;
  endtask

  always @(posedge clk) begin
    cyc_n <= cyc_n + 1;
    if (cyc_n == 150000) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc_n, 0);
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int h, bad;
    rst = 1'b1; active = 1'b0; mode_wr = 1'b0; mode_val = 1'b0; parm_wr = 1'b0;
    period_val = '0; count_val = '0; evt = 1'b0; tick = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cyc(0, 0);
    chk(irq == 1'b0, "R1 reset irq", int'(irq), 0);

    // R1 defaults: count 32, period 16, interrupt-start
    go(1);
    run(40, 0, 1, h);
    chk(h == 0, "R10 idle ticks", h, 0);
    run(31, 1, 0, h);
    chk(h == 0, "R1 31 events", h, 0);
    cyc(1, 0);
    chk(last_irq == 1'b1, "R1 32nd event", int'(last_irq), 1);
    cyc(1, 0);
    run(15, 0, 1, h);
    chk(h == 0, "R1 15 ticks", h, 0);
    cyc(0, 1);
    chk(last_irq == 1'b1, "R1 16th tick", int'(last_irq), 1);

    // R2 count sweep, both modes, timer out of reach
    for (int m = 0; m < 2; m++) begin
      for (int c = 1; c <= 6; c++) begin
        setup(m[0], 200, c);
        bad = 0;
        for (int i = 0; i < 3 * c; i++) begin
          cyc(1, 1);
          if (last_irq != ((i % c) == c - 1)) bad++;
        end
        chk(bad == 0, "R2 count sweep", bad, 0);
      end
    end

    // R3 interrupt-start: second event does not restart
    for (int p = 1; p <= 5; p++) begin
      for (int k = 0; k < p; k++) begin
        setup(0, p, 0);
        cyc(1, 0);
        run(k, 0, 1, h);
        cyc(1, 0);
        bad = h + int'(last_irq);
        run(p - k - 1, 0, 1, h);
        bad += h;
        cyc(0, 1);
        chk(bad == 0 && last_irq, "R3 period sweep", bad, 0);
      end
    end

    // R4 completion-start: second event restarts
    for (int p = 1; p <= 5; p++) begin
      for (int k = 0; k < p; k++) begin
        setup(1, p, 0);
        cyc(1, 0);
        run(k, 0, 1, h);
        cyc(1, 0);
        bad = h + int'(last_irq);
        run(p - 1, 0, 1, h);
        bad += h;
        cyc(0, 1);
        chk(bad == 0 && last_irq, "R4 restart sweep", bad, 0);
      end
    end

    // R4 burst never expires, then one period after the last event
    setup(1, 2, 0);
    bad = 0;
    for (int i = 0; i < 20; i++) begin
      cyc(1, 0); bad += int'(last_irq);
      cyc(0, 1); bad += int'(last_irq);
    end
    cyc(1, 0); bad += int'(last_irq);
    cyc(0, 1); bad += int'(last_irq);
    chk(bad == 0, "R4 burst silent", bad, 0);
    cyc(0, 1);
    chk(last_irq == 1'b1, "R4 after burst", int'(last_irq), 1);

    // R5 mode defaults
    setup(0, 0, 0);
    go(0); wr_mode(1); go(1);
    cyc(1, 0);
    run(2, 0, 1, h);
    cyc(0, 1);
    chk(h == 0 && last_irq, "R5 evt-start period 3", h, 0);
    run(31, 1, 0, h);
    cyc(1, 0);
    chk(h == 0 && last_irq, "R5 evt-start count 32", h, 0);
    go(0); wr_mode(0); go(1);
    cyc(1, 0);
    run(15, 0, 1, h);
    cyc(0, 1);
    chk(h == 0 && last_irq, "R5 irq-start period 16", h, 0);

    // R6 simultaneous mode and parm write
    go(0);
    mode_wr = 1'b1; mode_val = 1'b1; parm_wr = 1'b1; period_val = 8'd2; count_val = 8'd0;
    cyc(0, 0);
    mode_wr = 1'b0; parm_wr = 1'b0;
    go(1);
    cyc(1, 0);
    cyc(0, 1); bad = int'(last_irq);
    cyc(1, 0); bad += int'(last_irq);
    cyc(0, 1); bad += int'(last_irq);
    cyc(0, 1);
    chk(bad == 0 && last_irq, "R6 combined write", bad, 0);

    // R7 writes while active ignored
    setup(0, 0, 4);
    mode_wr = 1'b1; mode_val = 1'b1; parm_wr = 1'b1; period_val = 8'd0; count_val = 8'd1;
    cyc(0, 0);
    mode_wr = 1'b0; parm_wr = 1'b0;
    run(3, 1, 0, h);
    cyc(1, 0);
    chk(h == 0 && last_irq, "R7 active write ignored", h, 0);

    // R8 going down discards pending
    run(3, 1, 0, h);
    active = 1'b0;
    run(6, 1, 1, h);
    chk(h == 0, "R8 inactive quiet", h, 0);
    go(1);
    run(3, 1, 0, h);
    cyc(1, 0);
    chk(h == 0 && last_irq, "R8 pending discarded", h, 0);

    // R9 moderation off
    setup(0, 0, 0);
    cyc(1, 0); bad = int'(!last_irq);
    cyc(0, 1); bad += int'(last_irq);
    cyc(1, 0); bad += int'(!last_irq);
    cyc(1, 0); bad += int'(!last_irq);
    cyc(0, 0); bad += int'(last_irq);
    chk(bad == 0, "R9 every event", bad, 0);

    // R11 event during irq cycle, count path
    setup(0, 0, 2);
    cyc(1, 0); bad = int'(last_irq);
    cyc(1, 0); bad += int'(!last_irq);
    cyc(1, 0); bad += int'(last_irq);
    cyc(1, 0);
    chk(bad == 0 && last_irq, "R11 count carry", bad, 0);

    // R11 event during irq cycle restarts timer; R10 idle afterwards
    setup(1, 3, 0);
    cyc(1, 0);
    run(2, 0, 1, h);
    cyc(0, 1);
    bad = h + int'(!last_irq);
    cyc(1, 0); bad += int'(last_irq);
    run(2, 0, 1, h); bad += h;
    cyc(0, 1);
    chk(bad == 0 && last_irq, "R11 timer carry", bad, 0);
    run(20, 0, 1, h);
    chk(h == 0, "R10 no repeat when idle", h, 0);

    // R12 no ticks, no expiry
    setup(0, 2, 0);
    cyc(1, 0);
    run(50, 0, 0, h);
    chk(h == 0, "R12 tick only", h, 0);
    run(2, 0, 1, h);
    chk(h == 1 && last_irq, "R12 expiry on ticks", h, 1);

    // R12 coincident count and expiry -> one pulse
    setup(0, 3, 2);
    cyc(1, 0);
    run(2, 0, 1, h);
    cyc(1, 1);
    bad = h + int'(!last_irq);
    cyc(0, 0); bad += int'(last_irq);
    chk(bad == 0, "R12 single pulse", bad, 0);

    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule